// File: doc/BRIEF.md
# Programmable Pseudo-Random Bit Sequence Generator

This block produces a serial test bit stream for bit-error-rate measurement. A shift register of up to 32 stages runs as a Fibonacci linear feedback register. The feedback bit is the XOR of the stages picked by a tap mask. The raw output is taken from the last active stage, which is set by a length register. A host loads the mask, the seed, the length and a small control word through a single-cycle register write port. It then pulses a bit-clock enable once for every bit it wants to transmit.

Every raw bit passes through a 15-stage lookahead line before it reaches the output pin. When the zero-suppression mode is on, the bit that leaves the line is forced to 1 whenever the 14 bits queued behind it are all zero. This guarantees that the line never carries more than 14 consecutive zeros. The substitution acts on the output only and never reaches the shift register, so the underlying sequence and its period are unchanged.

The reset configuration is the 20-stage polynomial with feedback from stages 17 and 20, which is the usual basis for the zero-suppressed test pattern.

Top module: `prbs_gen`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) sets every shift-register stage to 1 and fills the lookahead line with ones, so `dout` reads 1. It also restores the defaults: taps at stages 17 and 20 (mask 0x0009_0000), length 20, seed 1, zero-suppression off.
- R2: The shift register and the lookahead line change only on a clock edge where `bit_en` is high. With `bit_en` low, `dout` holds its value whatever is written to the tap, seed or length registers.
- R3: Stage k of the register is bit k-1 of the state. On each enabled step the state shifts toward the higher stages, and the new stage-1 bit is the XOR of all stages whose bit is set in the tap mask (address 0).
- R4: The length register (address 2, bits [4:0]) holds L-1 for a length L of 1 to 32. The raw bit is read from stage L, and after each step every stage above L is 0.
- R5: A write to the control register (address 3) copies the seed register (address 1), masked to the active length, into the shift register. This happens only when the write sets bit 0 and the previously written bit 0 was 0. Writing 1 to bit 0 again has no effect.
- R6: When the masked seed is all zero, the value 1 (only stage 1 set) is loaded instead, so the generator never locks up.
- R7: Each raw bit reaches `dout` after exactly 15 enabled steps through the lookahead line. `dout` presents the oldest queued bit.
- R8: With control bit 1 set, `dout` is 1 whenever the 14 raw bits queued behind the presented bit are all 0. The shift register sequence is unaffected by this.
- R9: With a maximal-length tap set, the stream repeats with period 2^L-1. For example, L=5 with taps at stages 5 and 3 repeats every 31 bits and carries 16 ones per period.
- R10: While zero-suppression is enabled, `dout` never shows more than 14 consecutive zeros over enabled steps.
- R11: On the cycle a seed load takes place, the register does not shift and the lookahead line does not advance, even when `bit_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 tap mask, 1 seed, 2 length-1, 3 control (bit0 load, bit1 zero-suppress) |
| wr_data | input | 32 | Write data |
| bit_en | input | 1 | Advance one bit this cycle |
| dout | output | 1 | Serial test pattern |

## Verification
The stream is compared bit by bit against a reference model under four configurations. The all-ones reset state on the default 20-stage polynomial exercises the feedback taps and the output stage selection. A 5-stage maximal polynomial confirms the 31-bit period and the stage masking. A single-one seed on the 20-stage polynomial, run with suppression off and then on, yields a raw run of 19 zeros against a suppressed run of exactly 14, which isolates the forcing rule from the shift register. Repeated load writes, an all-zero seed and a load coinciding with `bit_en` separate edge from level triggering, show the lock-up guard, and confirm that a load takes priority over a shift. A long suppressed run bounds the zero runs on the default pattern.

// File: rtl/prbs_gen.sv
module prbs_gen #(
  parameter int              W       = 32,
  parameter int              LOOK    = 14,
  parameter logic [W-1:0]    TAP_RST = 32'h0009_0000,
  parameter int              LEN_RST = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic          bit_en,
  output logic          dout
);
  localparam int            LW  = $clog2(W);
  localparam int            PD  = LOOK + 1;
  localparam int            ZW  = $clog2(PD + 2);
  localparam logic [LW-1:0] TOP = LW'(W - 1);

  logic [W-1:0]  taps, seed, sr;
  logic [LW-1:0] lsel;
  logic          qrss, ld_q;
  logic [PD-1:0] pipe;

  wire          ctl_wr  = wr_en && (wr_addr == 2'd3);
  wire          ld_fire = ctl_wr && wr_data[0] && !ld_q;
  wire [W-1:0]  lmask   = {W{1'b1}} >> (TOP - lsel);
  wire [W-1:0]  seed_m  = seed & lmask;
  wire [W-1:0]  ld_val  = (seed_m == '0) ? W'(1) : seed_m;
  wire          fb      = ^(sr & taps);
  wire          raw     = sr[lsel];

  assign dout = pipe[PD-1] | (qrss & ~|pipe[PD-2:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      taps <= TAP_RST;
      seed <= W'(1);
      lsel <= LW'(LEN_RST - 1);
      qrss <= 1'b0;
      ld_q <= 1'b0;
      sr   <= '1;
      pipe <= '1;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          2'd0: taps <= wr_data;
          2'd1: seed <= wr_data;
          2'd2: lsel <= wr_data[LW-1:0];
          default: begin
            ld_q <= wr_data[0];
            qrss <= wr_data[1];
          end
        endcase
      end
      if (ld_fire) begin
        sr <= ld_val;
      end else if (bit_en) begin
        sr   <= {sr[W-2:0], fb} & lmask;
        pipe <= {pipe[PD-2:0], raw};
      end
    end
  end

  logic [ZW-1:0] zrun;
  always_ff @(posedge clk) begin
    if (rst || !qrss)
      zrun <= '0;
    else if (bit_en && !ld_fire)
      zrun <= dout ? '0 : ((zrun == ZW'(PD + 1)) ? zrun : zrun + 1'b1);
  end

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!bit_en && !ld_fire) |=> ($stable(sr) && $stable(pipe)));

  // R6
  seed_nz_chk: assert property (@(posedge clk) disable iff (rst)
    ld_fire |=> (sr != '0));

  // R4
  len_chk: assert property (@(posedge clk) disable iff (rst)
    (bit_en && !ld_fire) |=> ((sr & ~$past(lmask)) == '0));

  // R7
  pipe_chk: assert property (@(posedge clk) disable iff (rst)
    (bit_en && !ld_fire) |=> (pipe[0] == $past(raw)));

  // R5
  edge_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && wr_data[0] && ld_q && !bit_en) |=> $stable(sr));

  // R11
  ldpri_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_fire && bit_en) |=> $stable(pipe));

  // R10
  run_chk: assert property (@(posedge clk) disable iff (rst)
    zrun <= ZW'(LOOK));
endmodule

// File: tb/sim_prbs_gen.sv
module sim_prbs_gen;
  logic        clk = 0, rst = 1, wr_en = 0, bit_en = 0;
  logic [1:0]  wr_addr = 0;
  logic [31:0] wr_data = 0;
  logic        dout;

  prbs_gen u0 (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
               .wr_data(wr_data), .bit_en(bit_en), .dout(dout));

  always #5 clk = ~clk;

  int checks = 0, failures = 0;
  string cur_req = "R1";
  logic exp_q[$];
  logic hist[$];

  logic [31:0] m_taps, m_seed, m_sr;
  logic [4:0]  m_lsel;
  logic        m_qrss, m_ldq;
  logic [14:0] m_pipe;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] m_mask();
    return 32'hFFFF_FFFF >> (5'd31 - m_lsel);
  endfunction

  function automatic logic m_dout();
    return m_pipe[14] | (m_qrss && m_pipe[13:0] == '0);
  endfunction

  task automatic m_reset();
    m_taps = 32'h0009_0000; m_seed = 1; m_lsel = 19; m_qrss = 0; m_ldq = 0;
    m_sr = '1; m_pipe = '1;
  endtask

  task automatic m_adv();
    logic f, r;
    f = ^(m_sr & m_taps);
    r = m_sr[m_lsel];
    m_pipe = {m_pipe[13:0], r};
    m_sr = {m_sr[30:0], f} & m_mask();
  endtask

  task automatic m_wr(logic [1:0] a, logic [31:0] d, bit be);
    logic fire;
    logic [31:0] sv;
    fire = (a == 3) && d[0] && !m_ldq;
    if (fire) begin
      sv = m_seed & m_mask();
      m_sr = (sv == 0) ? 32'd1 : sv;
    end else if (be) m_adv();
    case (a)
      0: m_taps = d;
      1: m_seed = d;
      2: m_lsel = d[4:0];
      default: begin m_ldq = d[0]; m_qrss = d[1]; end
    endcase
  endtask

  // monitor: pops expected bits as the design emits them
  always @(negedge clk) begin
    if (!rst && bit_en) begin
      if (exp_q.size() == 0) chk(cur_req, 32'(dout), 32'hDEAD);
      else chk(cur_req, 32'(dout), 32'(exp_q.pop_front()));
      hist.push_back(dout);
    end
  end

  task automatic run_bits(int n);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(m_dout());
      bit_en = 1;
      @(posedge clk); m_adv(); #1;
    end
    bit_en = 0;
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d, bit be);
    wr_en = 1; wr_addr = a; wr_data = d; bit_en = be;
    if (be) exp_q.push_back(m_dout());
    @(posedge clk); m_wr(a, d, be); #1;
    wr_en = 0; bit_en = 0;
  endtask

  task automatic do_reset();
    rst = 1; wr_en = 0; bit_en = 0;
    repeat (3) @(posedge clk);
    m_reset(); #1; rst = 0;
  endtask

  function automatic int max_zero_run();
    int run = 0, best = 0;
    foreach (hist[i]) begin
      run = hist[i] ? 0 : run + 1;
      if (run > best) best = run;
    end
    return best;
  endfunction

  initial begin
    #2_000_000;
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic held;
    int mism, ones;
    // R1 reset state and default polynomial
    do_reset();
    #4; chk("R1", 32'(dout), 1); #1;
    @(posedge clk); #1;
    cur_req = "R3"; run_bits(60);

    // R2 idle with register writes: no change
    held = dout;
    wr(0, 32'h0000_00FF, 0); wr(2, 32'd7, 0);
    wr(0, 32'h0009_0000, 0); wr(2, 32'd19, 0);
    wr(1, 32'h000A_BCDE, 0);
    repeat (4) begin @(negedge clk); chk("R2", 32'(dout), 32'(held)); end
    @(posedge clk); #1;
    cur_req = "R2"; run_bits(20);

    // R5 edge-triggered load
    wr(3, 32'h1, 0); cur_req = "R5"; run_bits(20);
    wr(3, 32'h1, 0); run_bits(20);
    wr(3, 32'h0, 0); wr(3, 32'h1, 0); run_bits(30);

    // R6 zero seed guard
    wr(3, 32'h0, 0); wr(1, 32'h0, 0); wr(3, 32'h1, 0);
    cur_req = "R6"; run_bits(40);

    // R11 load on an enabled cycle
    wr(3, 32'h0, 0); wr(1, 32'h0001_2345, 0);
    cur_req = "R11"; wr(3, 32'h1, 1); run_bits(30);

    // R4 / R9 short maximal polynomial
    do_reset(); @(posedge clk); #1;
    wr(0, 32'h0000_0014, 0); wr(2, 32'd4, 0); wr(1, 32'h0000_00FF, 0);
    wr(3, 32'h1, 0); wr(3, 32'h0, 0);
    cur_req = "R4"; run_bits(15);
    hist.delete(); cur_req = "R9"; run_bits(62);
    mism = 0; ones = 0;
    for (int k = 0; k < 31; k++) begin
      if (hist[k] !== hist[k+31]) mism++;
      if (hist[k]) ones++;
    end
    chk("R9", mism, 0);
    chk("R9", ones, 16);

    // R8 contrast: raw run vs suppressed run from a single-one seed
    do_reset(); @(posedge clk); #1;
    wr(3, 32'h1, 0); wr(3, 32'h0, 0);
    cur_req = "R7"; run_bits(15);
    hist.delete(); cur_req = "R8"; run_bits(20);
    chk("R8", max_zero_run(), 19);

    do_reset(); @(posedge clk); #1;
    wr(3, 32'h3, 0); wr(3, 32'h2, 0);
    cur_req = "R7"; run_bits(15);
    hist.delete(); cur_req = "R8"; run_bits(20);
    chk("R8", max_zero_run(), 14);
    chk("R8", 32'({hist[0], hist[1], hist[2], hist[3], hist[4], hist[5]}), 32'b111110);

    // R10 long suppressed run on default polynomial
    wr(0, 32'h0009_0000, 0); wr(1, 32'h0000_0001, 0);
    wr(3, 32'h3, 0); wr(3, 32'h2, 0);
    hist.delete(); cur_req = "R10"; run_bits(3000);
    chk("R10", 32'(max_zero_run() <= 14), 1);

    @(posedge clk); #1;
    chk("R1", 32'(exp_q.size()), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule